// File: doc/BRIEF.md
# Single-Line Cache Maintenance Engine

This block carries out one maintenance action on one line of a two-way set-associative cache. Software first loads a persistent line-command register with an action code and a locate-by-address flag. It then writes a line address register with the start bit set. The engine rounds the address down to a 16-byte line boundary, looks the tag up in both ways of the indexed set, and applies the action to the way that matches. The actions are drop the line, write it back, or write it back and drop it. A modified line is written back over a request/acknowledge handshake before its state bits are changed.

The engine owns the valid, modified and tag bits of the cache. The cache's allocation path marks lines through a fill port, and its hit path reads them through a probe port. The controller has three states. IDLE waits for a start. LOOKUP is the single cycle in which the tag compare is made. WBACK holds the writeback request until it is acknowledged. The transitions are IDLE to LOOKUP on a start. LOOKUP goes back to IDLE on a miss, a no-op, a clean push, an invalidate or a clean clear. LOOKUP goes to WBACK on a push or clear of a modified line. WBACK goes to IDLE on acknowledge.

Top module: `lce_line_engine`

## Requirements
- R1: The line address register stores the written address with its low four bits forced to zero, so an unaligned address acts on the 16-byte line that contains it, and `wb_addr` carries that aligned address.
- R2: A command compares the tag in both ways of the indexed set and acts on whichever way holds the line, way 1 as well as way 0.
- R3: Code 1 (invalidate) on a hit clears the valid and modified bits of the line without any writeback, whether or not the line was modified.
- R4: Code 2 (push) on a modified hit raises one writeback request for the line and afterwards leaves it valid and unmodified. On a clean hit it makes no request and changes nothing.
- R5: Code 3 (clear) on a modified hit raises one writeback request and then clears valid and modified. On a clean hit it clears valid with no request.
- R6: `line_busy` reads 1 from the cycle after a start write until the command finishes, then 0. A command that makes no writeback finishes after exactly one busy cycle.
- R7: The command code and the locate-by-address flag keep their values across any number of commands and change only on `cmd_wr`.
- R8: Code 0 is a no-op: it leaves every line unchanged and makes no request.
- R9: With the locate-by-address flag at 0, a start completes without a request and without any state change.
- R10: A write to the address register while `line_busy` is 1 is ignored: the stored address does not change and no second command starts.
- R11: After reset the engine is idle, makes no request, holds command code 0 and flag 0, and every line is invalid.
- R12: `wb_req` stays at 1, with `wb_addr` stable, until a cycle with `wb_ack` at 1, and is seen only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Write strobe of the line-command register |
| cmd_code_in | input | 2 | Action code: 0 no-op, 1 invalidate, 2 push, 3 clear |
| cmd_by_addr_in | input | 1 | Locate-by-physical-address flag to store |
| lcmd_code | output | 2 | Stored action code |
| lcmd_by_addr | output | 1 | Stored locate-by-address flag |
| adr_wr | input | 1 | Write strobe of the line address register |
| adr_wdata | input | ADDR_W | Physical address to store |
| adr_go | input | 1 | Start bit written with the address |
| line_addr | output | ADDR_W | Stored, line-aligned address |
| line_busy | output | 1 | Start bit readback: 1 while a command runs |
| wb_req | output | 1 | Writeback request for a modified line |
| wb_addr | output | ADDR_W | Line address being written back |
| wb_ack | input | 1 | Writeback acknowledge |
| fill_en | input | 1 | Allocate a line (sets valid and tag) |
| fill_way | input | 1 | Way to allocate into |
| fill_addr | input | ADDR_W | Address of the allocated line |
| fill_dirty | input | 1 | Modified bit of the allocated line |
| probe_addr | input | ADDR_W | Address looked up by the hit path |
| probe_hit | output | 1 | Line present in either way |
| probe_way | output | 1 | Way that holds the probed line |
| probe_dirty | output | 1 | Modified bit of the probed line |

## Verification
The assertions assume a few things about the inputs. The fill port is quiet while `line_busy` is 1. `wb_ack` is given only while `wb_req` is high. A tag is never allocated into both ways of one set. The bench honours this in four ways. It fills only between commands. It raises acknowledge one cycle at a time after seeing a request. It refills a line into the way that already holds its tag. It writes the command register only while idle. Within these limits the stimulus draws random tags from a small pool, so hits and misses in either way are frequent. It also draws random action codes, random low address bits and the occasional cleared flag.

// File: rtl/lce_pkg.sv
package lce_pkg;

    typedef enum logic [1:0] {
        LC_NOP   = 2'd0,
        LC_INVAL = 2'd1,
        LC_PUSH  = 2'd2,
        LC_CLEAR = 2'd3
    } lc_code_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WBACK  = 2'd2
    } lc_state_e;

endpackage

// File: rtl/lce_tag_store.sv
module lce_tag_store #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic              upd_en,
    input  logic              upd_way,
    input  logic              upd_valid,
    input  logic              upd_dirty,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_hit,
    output logic              look_way,
    output logic              look_dirty,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_way,
    output logic              probe_dirty
);
    localparam int SETS  = 1 << IDX_W;
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int WAYS  = 2;

    logic [IDX_W-1:0] l_idx, p_idx, f_idx;
    logic [TAG_W-1:0] l_tag, p_tag, f_tag;
    logic [WAYS-1:0]  l_hit, l_dty, p_hit, p_dty;

    assign l_idx = look_addr[OFF_W +: IDX_W];
    assign p_idx = probe_addr[OFF_W +: IDX_W];
    assign f_idx = fill_addr[OFF_W +: IDX_W];
    assign l_tag = look_addr[ADDR_W-1 -: TAG_W];
    assign p_tag = probe_addr[ADDR_W-1 -: TAG_W];
    assign f_tag = fill_addr[ADDR_W-1 -: TAG_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  dty;
        logic [TAG_W-1:0] tag [SETS];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld <= '0;
                dty <= '0;
            end else if (upd_en && (upd_way == w[0])) begin
                vld[l_idx] <= upd_valid;
                dty[l_idx] <= upd_dirty;
            end else if (fill_en && (fill_way == w[0])) begin
                vld[f_idx] <= 1'b1;
                dty[f_idx] <= fill_dirty;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_way == w[0]) && !(upd_en && (upd_way == w[0])))
                tag[f_idx] <= f_tag;
        end

        assign l_hit[w] = vld[l_idx] && (tag[l_idx] == l_tag);
        assign l_dty[w] = dty[l_idx];
        assign p_hit[w] = vld[p_idx] && (tag[p_idx] == p_tag);
        assign p_dty[w] = dty[p_idx];
    end

    // Way 0 wins if both ways were ever to match; fills keep tags unique per set.
    assign look_hit    = |l_hit;
    assign look_way    = !l_hit[0];
    assign look_dirty  = l_hit[0] ? l_dty[0] : l_dty[1];
    assign probe_hit   = |p_hit;
    assign probe_way   = !p_hit[0];
    assign probe_dirty = probe_hit && (p_hit[0] ? p_dty[0] : p_dty[1]);

endmodule

// File: rtl/lce_ctrl.sv
module lce_ctrl
    import lce_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start,
    input  lc_code_e start_code,
    input  logic     start_phys,
    input  logic     hit,
    input  logic     hit_way,
    input  logic     hit_dirty,
    input  logic     wb_ack,
    output logic     busy,
    output logic     wb_req,
    output logic     upd_en,
    output logic     upd_way,
    output logic     upd_valid,
    output logic     upd_dirty
);
    lc_state_e st, nxt;
    lc_code_e  act_code;
    logic      act_phys;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            act_code <= LC_NOP;
            act_phys <= 1'b0;
        end else begin
            st <= nxt;
            if (start && (st == ST_IDLE)) begin
                act_code <= start_code;
                act_phys <= start_phys;
            end
        end
    end

    always_comb begin
        nxt       = st;
        wb_req    = 1'b0;
        upd_en    = 1'b0;
        upd_valid = 1'b0;
        upd_dirty = 1'b0;
        upd_way   = hit_way;
        unique case (st)
            ST_IDLE: begin
                if (start) nxt = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                nxt = ST_IDLE;
                if (act_phys && hit) begin
                    unique case (act_code)
                        LC_NOP:   ;
                        LC_INVAL: upd_en = 1'b1;
                        LC_PUSH:  if (hit_dirty) nxt = ST_WBACK;
                        LC_CLEAR: begin
                            if (hit_dirty) nxt = ST_WBACK;
                            else           upd_en = 1'b1;
                        end
                    endcase
                end
            end
            ST_WBACK: begin
                wb_req = 1'b1;
                if (wb_ack) begin
                    upd_en    = 1'b1;
                    upd_valid = (act_code == LC_PUSH);
                    nxt       = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign busy = (st != ST_IDLE);

endmodule

// File: rtl/lce_line_engine.sv
module lce_line_engine
    import lce_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LINE_B = 16,
    parameter int SETS   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [1:0]        cmd_code_in,
    input  logic              cmd_by_addr_in,
    output logic [1:0]        lcmd_code,
    output logic              lcmd_by_addr,
    input  logic              adr_wr,
    input  logic [ADDR_W-1:0] adr_wdata,
    input  logic              adr_go,
    output logic [ADDR_W-1:0] line_addr,
    output logic              line_busy,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    input  logic              fill_en,
    input  logic              fill_way,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_dirty,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              probe_way,
    output logic              probe_dirty
);
    localparam int OFF_W = $clog2(LINE_B);
    localparam int IDX_W = $clog2(SETS);

    logic       start;
    logic       hit, hit_way, hit_dirty;
    logic       upd_en, upd_way, upd_valid, upd_dirty;
    lc_code_e   code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q       <= LC_NOP;
            lcmd_by_addr <= 1'b0;
            line_addr    <= '0;
        end else begin
            if (cmd_wr) begin
                code_q       <= lc_code_e'(cmd_code_in);
                lcmd_by_addr <= cmd_by_addr_in;
            end
            if (adr_wr && !line_busy)
                line_addr <= {adr_wdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        end
    end

    assign lcmd_code = code_q;
    assign start     = adr_wr && adr_go && !line_busy;
    assign wb_addr   = line_addr;

    lce_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_code (code_q),
        .start_phys (lcmd_by_addr),
        .hit        (hit),
        .hit_way    (hit_way),
        .hit_dirty  (hit_dirty),
        .wb_ack     (wb_ack),
        .busy       (line_busy),
        .wb_req     (wb_req),
        .upd_en     (upd_en),
        .upd_way    (upd_way),
        .upd_valid  (upd_valid),
        .upd_dirty  (upd_dirty)
    );

    lce_tag_store #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .fill_en     (fill_en),
        .fill_way    (fill_way),
        .fill_addr   (fill_addr),
        .fill_dirty  (fill_dirty),
        .upd_en      (upd_en),
        .upd_way     (upd_way),
        .upd_valid   (upd_valid),
        .upd_dirty   (upd_dirty),
        .look_addr   (line_addr),
        .look_hit    (hit),
        .look_way    (hit_way),
        .look_dirty  (hit_dirty),
        .probe_addr  (probe_addr),
        .probe_hit   (probe_hit),
        .probe_way   (probe_way),
        .probe_dirty (probe_dirty)
    );

endmodule

// File: rtl/lce_line_engine_chk.sv
module lce_line_engine_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_wr,
    input logic              adr_wr,
    input logic              adr_go,
    input logic              busy,
    input logic              wb_req,
    input logic              wb_ack,
    input logic [ADDR_W-1:0] wb_addr,
    input logic [ADDR_W-1:0] line_addr,
    input logic [1:0]        lcmd_code
);
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req);

    a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> $stable(wb_addr));

    a_r12_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy);

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(line_addr));

    a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        adr_wr && adr_go && !busy |=> busy);

    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> $stable(lcmd_code));

    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        line_addr[3:0] == 4'd0);

endmodule

bind lce_line_engine lce_line_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .adr_wr    (adr_wr),
    .adr_go    (adr_go),
    .busy      (line_busy),
    .wb_req    (wb_req),
    .wb_ack    (wb_ack),
    .wb_addr   (wb_addr),
    .line_addr (line_addr),
    .lcmd_code (lcmd_code)
);

// File: tb/lce_line_engine_tb.sv
module lce_line_engine_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_code_in = 2'd0;
    logic        cmd_by_addr_in = 1'b0;
    logic [1:0]  lcmd_code;
    logic        lcmd_by_addr;
    logic        adr_wr = 1'b0;
    logic [31:0] adr_wdata = '0;
    logic        adr_go = 1'b0;
    logic [31:0] line_addr;
    logic        line_busy;
    logic        wb_req;
    logic [31:0] wb_addr;
    logic        wb_ack = 1'b0;
    logic        fill_en = 1'b0;
    logic        fill_way = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_dirty = 1'b0;
    logic [31:0] probe_addr = '0;
    logic        probe_hit, probe_way, probe_dirty;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model of the line state
    bit        mv [2][16];
    bit        mm [2][16];
    bit [23:0] mt [2][16];
    bit [1:0]  m_code = 0;
    bit        m_phys = 0;

    always #(CLK_P/2) clk = ~clk;

    lce_line_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code_in(cmd_code_in),
        .cmd_by_addr_in(cmd_by_addr_in), .lcmd_code(lcmd_code), .lcmd_by_addr(lcmd_by_addr),
        .adr_wr(adr_wr), .adr_wdata(adr_wdata), .adr_go(adr_go), .line_addr(line_addr),
        .line_busy(line_busy), .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_en(fill_en), .fill_way(fill_way), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .probe_way(probe_way),
        .probe_dirty(probe_dirty)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mlook(input bit [31:0] a);
        for (int w = 0; w < 2; w++)
            if (mv[w][a[7:4]] && mt[w][a[7:4]] == a[31:8]) return w;
        return -1;
    endfunction

    function automatic string code_req(input bit [1:0] c);
        case (c)
            2'd1: return "R3";
            2'd2: return "R4";
            2'd3: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic set_cmd(input bit [1:0] c, input bit p);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_code_in = c; cmd_by_addr_in = p;
        @(negedge clk);
        cmd_wr = 1'b0;
        m_code = c; m_phys = p;
        chk(lcmd_code == c && lcmd_by_addr == p, "R7", {29'd0, lcmd_by_addr, lcmd_code}, {29'd0, p, c});
    endtask

    task automatic fill(input bit [31:0] a, input bit d);
        int w = mlook(a);
        bit way = (w >= 0) ? w[0] : bit'($urandom_range(0, 1));
        @(negedge clk);
        fill_en = 1'b1; fill_way = way; fill_addr = a; fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
        mv[way][a[7:4]] = 1; mm[way][a[7:4]] = d; mt[way][a[7:4]] = a[31:8];
    endtask

    task automatic probe_chk(input bit [31:0] a, input string req);
        int w = mlook(a);
        probe_addr = a;
        #1;
        chk(probe_hit == (w >= 0), req, {31'd0, probe_hit}, {31'd0, w >= 0});
        if (w >= 0) begin
            chk(probe_way == w[0] && probe_dirty == mm[w][a[7:4]], req,
                {30'd0, probe_way, probe_dirty}, {30'd0, w[0], mm[w][a[7:4]]});
        end
    endtask

    // Issue one command; optionally attempt a second address write while busy
    task automatic run_cmd(input bit [31:0] a, input bit poke);
        bit [31:0] al = {a[31:4], 4'd0};
        int w = mlook(a);
        bit act = m_phys && (m_code != 0) && (w >= 0);
        bit dirty = act && mm[w][a[7:4]];
        int exp_wb = (act && (m_code == 2 || m_code == 3) && dirty) ? 1 : 0;
        int nwb = 0;
        int cyc = 0;
        int held = 0;
        string rq = (!m_phys) ? "R9" : code_req(m_code);
        @(negedge clk);
        adr_wr = 1'b1; adr_go = 1'b1; adr_wdata = a;
        @(negedge clk);
        adr_wr = 1'b0; adr_go = 1'b0;
        chk(line_busy == 1'b1, "R6", {31'd0, line_busy}, 32'd1);
        chk(line_addr == al, "R1", line_addr, al);
        while (line_busy && cyc < 50) begin
            if (poke && cyc == 0) begin
                adr_wr = 1'b1; adr_go = 1'b1; adr_wdata = a ^ 32'h0000_0F00;
            end
            if (wb_req) begin
                held++;
                chk(wb_addr == al, "R12", wb_addr, al);
                if (held == 3) begin
                    wb_ack = 1'b1;
                    nwb++;
                end
            end
            @(negedge clk);
            adr_wr = 1'b0; adr_go = 1'b0; wb_ack = 1'b0;
            cyc++;
        end
        chk(nwb == exp_wb, rq, nwb, exp_wb);
        if (exp_wb == 0)
            chk(cyc == 1, "R6", cyc, 32'd1);
        chk(line_busy == 1'b0 && wb_req == 1'b0, "R6", {30'd0, line_busy, wb_req}, 32'd0);
        if (poke) begin
            chk(line_addr == al, "R10", line_addr, al);
            repeat (2) @(negedge clk);
            chk(line_busy == 1'b0, "R10", {31'd0, line_busy}, 32'd0);
        end
        if (act) begin
            case (m_code)
                2'd1: begin mv[w][a[7:4]] = 0; mm[w][a[7:4]] = 0; end
                2'd2: mm[w][a[7:4]] = 0;
                2'd3: begin mv[w][a[7:4]] = 0; mm[w][a[7:4]] = 0; end
                default: ;
            endcase
        end
        probe_chk(a, rq);
        chk(lcmd_code == m_code && lcmd_by_addr == m_phys, "R7",
            {29'd0, lcmd_by_addr, lcmd_code}, {29'd0, m_phys, m_code});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(line_busy == 0 && wb_req == 0, "R11", {30'd0, line_busy, wb_req}, 32'd0);
        chk(lcmd_code == 0 && lcmd_by_addr == 0, "R11", {29'd0, lcmd_by_addr, lcmd_code}, 32'd0);
        probe_chk(32'h0000_1230, "R11");

        // R2: line in way 1, dirty, push with unaligned address (R1)
        fill(32'hAAAA_0050, 1'b0);
        @(negedge clk);
        fill_en = 1'b1; fill_way = 1'b1; fill_addr = 32'hBBBB_0050; fill_dirty = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
        mv[1][5] = 1; mm[1][5] = 1; mt[1][5] = 24'hBBBB_00;
        probe_chk(32'hBBBB_0050, "R2");
        set_cmd(2'd2, 1'b1);
        run_cmd(32'hBBBB_005B, 1'b0);
        // R4 clean push: no writeback
        run_cmd(32'hBBBB_0050, 1'b0);
        // R10 poke while busy on a dirty clear
        fill(32'hBBBB_0050, 1'b1);
        set_cmd(2'd3, 1'b1);
        run_cmd(32'hBBBB_0057, 1'b1);
        // R5 clean clear
        run_cmd(32'hAAAA_0050, 1'b0);
        // R3 invalidate of a dirty line
        fill(32'hCCCC_0070, 1'b1);
        set_cmd(2'd1, 1'b1);
        run_cmd(32'hCCCC_0070, 1'b0);
        // R8 no-op and R9 flag cleared
        fill(32'hDDDD_0090, 1'b1);
        set_cmd(2'd0, 1'b1);
        run_cmd(32'hDDDD_0090, 1'b0);
        set_cmd(2'd3, 1'b0);
        run_cmd(32'hDDDD_0090, 1'b0);

        // Random mix
        for (int i = 0; i < 150; i++) begin
            bit [31:0] a = {22'h2A5, 2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                            4'($urandom_range(0, 15))};
            int sel = $urandom_range(0, 9);
            if (sel < 4)      fill(a, bit'($urandom_range(0, 1)));
            else if (sel < 5) set_cmd(2'($urandom_range(0, 3)), ($urandom_range(0, 7) != 0));
            else              run_cmd(a, ($urandom_range(0, 7) == 0));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule